// File: doc/BRIEF.md
# Base-Relative Inter-Core Queue Array

This block is a shared bank of hardware FIFO queues through which processor cores pass register values to one another while running a loop split into pipeline stages across threads. Every core has a produce port for pushing a word and a consume port for popping one. Each core also has a request to load its own queue-base register. A request never names a physical queue directly. It carries a virtual queue number, and the block adds the requesting core's base to that number to pick the physical queue.

Because the physical queue is chosen relative to a base that each core can rewrite, several cores can run the same code and still talk over separate physical channels. A producer can also deal work out to several replicated consumer threads in turn just by stepping its base. Each queue is a point-to-point FIFO. A push to a full queue or a pop from an empty one holds the request with ready low until it can complete, so no word is ever lost. When several cores aim requests of the same kind at one queue in a cycle, the lowest-numbered core is served.

Core count, queue count, queue depth and word width are parameters. A full-size build can use 512 queues of 32 words each. The default instance is small so that it is cheap to simulate.

Top module: `xcore_queue_array`

## Requirements
- R1: A granted produce (prod_valid and prod_ready both high at a rising edge) appends prod_data to the tail of the selected physical queue. Words leave each queue in the order they entered.
- R2: A granted consume returns the word at the head of the selected queue on cons_data, combinationally in the same cycle that cons_ready is high, and removes that word at the edge. cons_data reads zero whenever cons_ready is low.
- R3: The physical queue is (core base + virtual number) modulo the queue count. The queue count is a power of two, so a sum past the last queue wraps around to queue 0 and upward.
- R4: A base_set pulse from core c loads base_val into core c's base only. A produce or consume from that core in the same cycle still uses the old base, and requests from the following cycle on use the new one.
- R5: A produce to a full queue is held with prod_ready low, even when a pop from that queue is granted in the same cycle. A consume from an empty queue is held with cons_ready low. A held word is not written, and it is accepted once it is presented again after space frees.
- R6: A push and a pop to the same queue in one cycle are both granted when the queue is neither full nor empty, and the count does not change. A pop aimed at an empty queue in the same cycle as a push to it is stalled, and the pushed word can be popped on the next cycle.
- R7: Among cores pushing to the same physical queue in one cycle, only the lowest-indexed core can be granted. Pops to a shared queue are arbitrated in the same way, separately from pushes.
- R8: Reset (rst_n low, asynchronous) empties every queue and clears every base register to zero.
- R9: prod_ready is never high without prod_valid, and cons_ready is never high without cons_valid, on the same core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_set | input | NC | Per-core request to load the base register |
| base_val | input | NC*QW | Per-core new base value, QW bits per core |
| prod_valid | input | NC | Per-core produce request |
| prod_vq | input | NC*QW | Per-core virtual queue number for produce |
| prod_data | input | NC*DW | Per-core word to push |
| prod_ready | output | NC | Per-core produce accepted this cycle |
| cons_valid | input | NC | Per-core consume request |
| cons_vq | input | NC*QW | Per-core virtual queue number for consume |
| cons_ready | output | NC | Per-core consume accepted this cycle |
| cons_data | output | NC*DW | Per-core popped word, valid while cons_ready is high |

## Verification
A corrupt read or write pointer shows up at the first pop from the affected queue, either as a word out of order or as a stale word on cons_data. A count that is off by one either stalls a request that should pass or grants a pop from an empty queue, and this is visible on the ready outputs in the same cycle the queue is next used. A base register that loads the wrong value, or loads for the wrong core, sends the next request to the wrong physical queue. That is caught when the word turns up on a different virtual number, or when a pop finds its queue empty. For this reason the bench pushes and pops through different cores with different bases, so that every word takes a renamed path.

// File: rtl/xq_pkg.sv
package xq_pkg;
    // Which side of a queue an arbiter instance serves
    typedef enum logic {
        KIND_PUSH = 1'b0,
        KIND_POP  = 1'b1
    } xq_kind_e;
endpackage

// File: rtl/xq_base_file.sv
// Per-core queue-base registers and base-relative physical queue selection
module xq_base_file #(
    parameter int NC = 4,
    parameter int QW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    set_en,
    input  logic [NC*QW-1:0] set_val,
    input  logic [NC*QW-1:0] prod_vq,
    input  logic [NC*QW-1:0] cons_vq,
    output logic [NC*QW-1:0] prod_pq,
    output logic [NC*QW-1:0] cons_pq,
    output logic [NC*QW-1:0] base_flat
);
    typedef struct packed {
        logic [NC-1:0][QW-1:0] base;
    } base_st_t;

    base_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NC; c++) begin
            if (set_en[c]) s_d.base[c] = set_val[c*QW +: QW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Truncation to QW bits gives the modulo wrap (queue count is 2**QW)
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            prod_pq[c*QW +: QW]   = s_q.base[c] + prod_vq[c*QW +: QW];
            cons_pq[c*QW +: QW]   = s_q.base[c] + cons_vq[c*QW +: QW];
            base_flat[c*QW +: QW] = s_q.base[c];
        end
    end
endmodule

// File: rtl/xq_grant.sv
// Fixed lowest-index arbitration per physical queue, gated by queue state
module xq_grant #(
    parameter int NC = 4,
    parameter int NQ = 8,
    parameter int QW = 3,
    parameter xq_pkg::xq_kind_e KIND = xq_pkg::KIND_PUSH
) (
    input  logic [NC-1:0]    req_valid,
    input  logic [NC*QW-1:0] req_pq,
    input  logic [NQ-1:0]    q_full,
    input  logic [NQ-1:0]    q_empty,
    output logic [NC-1:0]    grant
);
    logic [NQ-1:0] blocked;

    generate
        if (KIND == xq_pkg::KIND_PUSH) begin : g_push_side
            assign blocked = q_full;
            logic unused_side;
            assign unused_side = ^q_empty;
        end else begin : g_pop_side
            assign blocked = q_empty;
            logic unused_side;
            assign unused_side = ^q_full;
        end
    endgenerate

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            grant[c] = req_valid[c] && !blocked[req_pq[c*QW +: QW]];
            for (int j = 0; j < NC; j++) begin
                if (j < c && req_valid[j] &&
                    req_pq[j*QW +: QW] == req_pq[c*QW +: QW]) begin
                    grant[c] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/xq_storage.sv
// Queue bank: per-queue ring storage, pointers and occupancy counts
module xq_storage #(
    parameter int NC    = 4,
    parameter int NQ    = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int QW    = 3,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    push_grant,
    input  logic [NC*QW-1:0] push_pq,
    input  logic [NC*DW-1:0] push_data,
    input  logic [NC-1:0]    pop_grant,
    input  logic [NC*QW-1:0] pop_pq,
    output logic [NQ-1:0]    q_full,
    output logic [NQ-1:0]    q_empty,
    output logic [NQ*DW-1:0] head,
    output logic [NQ*CW-1:0] q_count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [NQ-1:0][DEPTH-1:0][DW-1:0] mem;
        logic [NQ-1:0][PW-1:0]            wp;
        logic [NQ-1:0][PW-1:0]            rp;
        logic [NQ-1:0][CW-1:0]            cnt;
    } bank_st_t;

    bank_st_t s_d, s_q;

    logic [NQ-1:0]         push_hit;
    logic [NQ-1:0]         pop_hit;
    logic [NQ-1:0][DW-1:0] push_word;

    // Route granted requests to their queues (the arbiter allows one of each kind)
    always_comb begin
        push_hit  = '0;
        pop_hit   = '0;
        push_word = '0;
        for (int q = 0; q < NQ; q++) begin
            for (int c = 0; c < NC; c++) begin
                if (push_grant[c] && push_pq[c*QW +: QW] == QW'(q)) begin
                    push_hit[q]  = 1'b1;
                    push_word[q] = push_data[c*DW +: DW];
                end
                if (pop_grant[c] && pop_pq[c*QW +: QW] == QW'(q)) begin
                    pop_hit[q] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        s_d = s_q;
        for (int q = 0; q < NQ; q++) begin
            if (push_hit[q]) begin
                s_d.mem[q][s_q.wp[q]] = push_word[q];
                s_d.wp[q] = (s_q.wp[q] == PW'(DEPTH - 1)) ? '0 : s_q.wp[q] + PW'(1);
            end
            if (pop_hit[q]) begin
                s_d.rp[q] = (s_q.rp[q] == PW'(DEPTH - 1)) ? '0 : s_q.rp[q] + PW'(1);
            end
            s_d.cnt[q] = s_q.cnt[q] + CW'(push_hit[q]) - CW'(pop_hit[q]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            q_full[q]             = (s_q.cnt[q] == CW'(DEPTH));
            q_empty[q]            = (s_q.cnt[q] == '0);
            head[q*DW +: DW]      = s_q.mem[q][s_q.rp[q]];
            q_count[q*CW +: CW]   = s_q.cnt[q];
        end
    end
endmodule

// File: rtl/xcore_queue_array.sv
// Top: base-relative multi-queue array shared by NC cores
module xcore_queue_array #(
    parameter int NC    = 4,
    parameter int NQ    = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int QW   = $clog2(NQ),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    base_set,
    input  logic [NC*QW-1:0] base_val,
    input  logic [NC-1:0]    prod_valid,
    input  logic [NC*QW-1:0] prod_vq,
    input  logic [NC*DW-1:0] prod_data,
    output logic [NC-1:0]    prod_ready,
    input  logic [NC-1:0]    cons_valid,
    input  logic [NC*QW-1:0] cons_vq,
    output logic [NC-1:0]    cons_ready,
    output logic [NC*DW-1:0] cons_data
);
    logic [NC*QW-1:0] push_pq;
    logic [NC*QW-1:0] pop_pq;
    logic [NC*QW-1:0] base_flat;
    logic [NQ-1:0]    q_full;
    logic [NQ-1:0]    q_empty;
    logic [NQ*DW-1:0] head;
    logic [NQ*CW-1:0] q_count;

    xq_base_file #(.NC(NC), .QW(QW)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (base_set),
        .set_val   (base_val),
        .prod_vq   (prod_vq),
        .cons_vq   (cons_vq),
        .prod_pq   (push_pq),
        .cons_pq   (pop_pq),
        .base_flat (base_flat)
    );

    xq_grant #(.NC(NC), .NQ(NQ), .QW(QW), .KIND(xq_pkg::KIND_PUSH)) u_push_arb (
        .req_valid (prod_valid),
        .req_pq    (push_pq),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .grant     (prod_ready)
    );

    xq_grant #(.NC(NC), .NQ(NQ), .QW(QW), .KIND(xq_pkg::KIND_POP)) u_pop_arb (
        .req_valid (cons_valid),
        .req_pq    (pop_pq),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .grant     (cons_ready)
    );

    xq_storage #(.NC(NC), .NQ(NQ), .DEPTH(DEPTH), .DW(DW), .QW(QW), .CW(CW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_grant (prod_ready),
        .push_pq    (push_pq),
        .push_data  (prod_data),
        .pop_grant  (cons_ready),
        .pop_pq     (pop_pq),
        .q_full     (q_full),
        .q_empty    (q_empty),
        .head       (head),
        .q_count    (q_count)
    );

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            cons_data[c*DW +: DW] = cons_ready[c] ? head[pop_pq[c*QW +: QW]*DW +: DW] : '0;
        end
    end
endmodule

// File: rtl/xq_checker.sv
// Assertion checker bound to the queue array top
module xq_checker #(
    parameter int NC    = 4,
    parameter int NQ    = 8,
    parameter int DEPTH = 4,
    parameter int QW    = 3,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NC-1:0]    base_set,
    input logic [NC*QW-1:0] base_val,
    input logic [NC*QW-1:0] base_flat,
    input logic [NC-1:0]    prod_valid,
    input logic [NC-1:0]    prod_ready,
    input logic [NC-1:0]    cons_valid,
    input logic [NC-1:0]    cons_ready,
    input logic [NC*QW-1:0] push_pq,
    input logic [NC*QW-1:0] pop_pq,
    input logic [NQ*CW-1:0] q_count
);
    logic [NQ-1:0][NC-1:0] push_by;
    logic [NQ-1:0][NC-1:0] pop_by;
    logic [NC-1:0]         pop_on_empty;

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            for (int c = 0; c < NC; c++) begin
                push_by[q][c] = prod_ready[c] && push_pq[c*QW +: QW] == QW'(q);
                pop_by[q][c]  = cons_ready[c] && pop_pq[c*QW +: QW] == QW'(q);
            end
        end
        for (int c = 0; c < NC; c++) begin
            pop_on_empty[c] = cons_ready[c] && (q_count[pop_pq[c*QW +: QW]*CW +: CW] == '0);
        end
    end

    // R9: ready only with a request
    a_r9_prod_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_ready & ~prod_valid) == '0);
    a_r9_cons_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_ready & ~cons_valid) == '0);

    // R5: consume never granted on an empty queue
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_on_empty == '0);

    genvar gq, gc;
    generate
        for (gq = 0; gq < NQ; gq++) begin : g_q
            // R7: at most one grant of each kind per queue per cycle
            a_r7_one_push: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(push_by[gq]));
            a_r7_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(pop_by[gq]));
            // R5: occupancy never exceeds the depth
            a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
                q_count[gq*CW +: CW] <= CW'(DEPTH));
            // R1: a lone push raises occupancy by one
            a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
                (push_by[gq] != '0 && pop_by[gq] == '0) |=>
                q_count[gq*CW +: CW] == $past(q_count[gq*CW +: CW]) + CW'(1));
            // R6: simultaneous push and pop leave occupancy unchanged
            a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (push_by[gq] != '0 && pop_by[gq] != '0) |=>
                $stable(q_count[gq*CW +: CW]));
        end
        for (gc = 0; gc < NC; gc++) begin : g_c
            // R4: base load takes the written value, otherwise holds
            a_r4_base_load: assert property (@(posedge clk) disable iff (!rst_n)
                base_set[gc] |=> base_flat[gc*QW +: QW] == $past(base_val[gc*QW +: QW]));
            a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !base_set[gc] |=> $stable(base_flat[gc*QW +: QW]));
        end
    endgenerate
endmodule

bind xcore_queue_array xq_checker #(
    .NC(NC), .NQ(NQ), .DEPTH(DEPTH), .QW(QW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_set   (base_set),
    .base_val   (base_val),
    .base_flat  (base_flat),
    .prod_valid (prod_valid),
    .prod_ready (prod_ready),
    .cons_valid (cons_valid),
    .cons_ready (cons_ready),
    .push_pq    (push_pq),
    .pop_pq     (pop_pq),
    .q_count    (q_count)
);

// File: tb/sim_xcore_queue_array.sv
module sim_xcore_queue_array;
    localparam int CLK_PERIOD = 10;
    localparam int NC    = 4;
    localparam int NQ    = 8;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int QW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NC-1:0] pv, cv, bs;
    logic [QW-1:0] pvq [NC];
    logic [QW-1:0] cvq [NC];
    logic [QW-1:0] bv  [NC];
    logic [DW-1:0] pd  [NC];

    logic [NC*QW-1:0] base_val_f, prod_vq_f, cons_vq_f;
    logic [NC*DW-1:0] prod_data_f, cons_data_f;
    logic [NC-1:0]    prod_ready, cons_ready;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            base_val_f[c*QW +: QW]  = bv[c];
            prod_vq_f[c*QW +: QW]   = pvq[c];
            cons_vq_f[c*QW +: QW]   = cvq[c];
            prod_data_f[c*DW +: DW] = pd[c];
        end
    end

    xcore_queue_array #(.NC(NC), .NQ(NQ), .DEPTH(DEPTH), .DW(DW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_set   (bs),
        .base_val   (base_val_f),
        .prod_valid (pv),
        .prod_vq    (prod_vq_f),
        .prod_data  (prod_data_f),
        .prod_ready (prod_ready),
        .cons_valid (cv),
        .cons_vq    (cons_vq_f),
        .cons_ready (cons_ready),
        .cons_data  (cons_data_f)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        pv = '0; cv = '0; bs = '0;
        for (int c = 0; c < NC; c++) begin
            pvq[c] = '0; cvq[c] = '0; bv[c] = '0; pd[c] = '0;
        end
    endtask

    // Start a new cycle: inputs change just after the falling edge
    task automatic next_cycle();
        @(negedge clk);
        clear_all();
    endtask

    task automatic push(input int c, input int vq, input int d);
        pv[c] = 1'b1; pvq[c] = QW'(vq); pd[c] = DW'(d);
    endtask

    task automatic pop(input int c, input int vq);
        cv[c] = 1'b1; cvq[c] = QW'(vq);
    endtask

    task automatic setb(input int c, input int b);
        bs[c] = 1'b1; bv[c] = QW'(b);
    endtask

    function automatic int pdata(input int c);
        return int'(cons_data_f[c*DW +: DW]);
    endfunction

    // op: 0 push, 1 pop, 2 set base
    typedef struct packed {
        logic [1:0]  core;
        logic [1:0]  op;
        logic [2:0]  vq;
        logic [15:0] data;
        logic        rdy;
        logic [15:0] rdata;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{2'd0, 2'd0, 3'd1, 16'h1111, 1'b1, 16'h0000}, // R1 push q1
        '{2'd0, 2'd0, 3'd1, 16'h2222, 1'b1, 16'h0000}, // R1 push q1
        '{2'd1, 2'd1, 3'd1, 16'h0000, 1'b1, 16'h1111}, // R2 oldest first
        '{2'd2, 2'd2, 3'd0, 16'h0005, 1'b0, 16'h0000}, // R4 core2 base=5
        '{2'd2, 2'd0, 3'd4, 16'h3333, 1'b1, 16'h0000}, // R3 5+4 wraps to q1
        '{2'd3, 2'd1, 3'd1, 16'h0000, 1'b1, 16'h2222}, // R1 order kept
        '{2'd3, 2'd1, 3'd1, 16'h0000, 1'b1, 16'h3333}, // R3 wrapped word in q1
        '{2'd3, 2'd1, 3'd1, 16'h0000, 1'b0, 16'h0000}, // R5 empty stalls
        '{2'd1, 2'd2, 3'd0, 16'h0002, 1'b0, 16'h0000}, // R4 core1 base=2
        '{2'd0, 2'd0, 3'd3, 16'h4444, 1'b1, 16'h0000}, // R4 core0 base still 0 -> q3
        '{2'd1, 2'd1, 3'd1, 16'h0000, 1'b1, 16'h4444}, // R4 core1 vq1 -> q3
        '{2'd2, 2'd1, 3'd6, 16'h0000, 1'b0, 16'h0000}  // R3 5+6 wraps to q3, empty
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R8, R9)
        next_cycle(); #1;
        chk("R9", "idle prod_ready", int'(prod_ready), 0);
        chk("R9", "idle cons_ready", int'(cons_ready), 0);
        next_cycle(); pop(0, 0); pop(1, 7); #1;
        chk("R8", "pop after reset stalls", int'(cons_ready), 0);
        chk("R2", "cons_data zero when stalled", pdata(0), 0);

        // Vector table
        for (int i = 0; i < 12; i++) begin
            next_cycle();
            case (TBL[i].op)
                2'd0: push(int'(TBL[i].core), int'(TBL[i].vq), int'(TBL[i].data));
                2'd1: pop(int'(TBL[i].core), int'(TBL[i].vq));
                default: setb(int'(TBL[i].core), int'(TBL[i].data));
            endcase
            #1;
            if (TBL[i].op == 2'd0)
                chk("R1/R3/R4", $sformatf("vec %0d prod_ready", i),
                    int'(prod_ready[TBL[i].core]), int'(TBL[i].rdy));
            if (TBL[i].op == 2'd1) begin
                chk("R2/R3/R5", $sformatf("vec %0d cons_ready", i),
                    int'(cons_ready[TBL[i].core]), int'(TBL[i].rdy));
                chk("R2", $sformatf("vec %0d cons_data", i),
                    pdata(int'(TBL[i].core)), int'(TBL[i].rdata));
            end
        end
        // bases now: c0=0, c1=2, c2=5, c3=0; all queues empty

        // R5: fill q6, then a push to the full queue stalls
        for (int k = 0; k < DEPTH; k++) begin
            next_cycle(); push(0, 6, 16'hA0 + k); #1;
            chk("R5", "fill push accepted", int'(prod_ready[0]), 1);
        end
        next_cycle(); push(0, 6, 16'hAF); #1;
        chk("R5", "push to full stalls", int'(prod_ready[0]), 0);
        next_cycle(); push(0, 6, 16'hAF); pop(3, 6); #1;
        chk("R5", "full push stalls despite pop", int'(prod_ready[0]), 0);
        chk("R2", "pop from full", pdata(3), 16'hA0);
        next_cycle(); push(0, 6, 16'hAF); #1;
        chk("R5", "held push accepted after space", int'(prod_ready[0]), 1);
        for (int k = 1; k <= DEPTH; k++) begin
            next_cycle(); pop(3, 6); #1;
            chk("R5", "drain order no loss", pdata(3), (k < DEPTH) ? (16'hA0 + k) : 16'hAF);
        end

        // R6: push and pop same non-empty queue (q2)
        next_cycle(); push(0, 2, 16'h5A5A); #1;
        next_cycle(); push(0, 2, 16'h6B6B); pop(1, 0); #1;
        chk("R6", "both push ready", int'(prod_ready[0]), 1);
        chk("R6", "both pop ready", int'(cons_ready[1]), 1);
        chk("R6", "both pop data", pdata(1), 16'h5A5A);
        next_cycle(); pop(3, 2); #1;
        chk("R6", "pushed word follows", pdata(3), 16'h6B6B);

        // R6: push to empty is not visible for a same-cycle pop (q4)
        next_cycle(); push(0, 4, 16'h7C7C); pop(3, 4); #1;
        chk("R6", "empty push ready", int'(prod_ready[0]), 1);
        chk("R6", "empty same-cycle pop stalls", int'(cons_ready[3]), 0);
        next_cycle(); pop(3, 4); #1;
        chk("R6", "word visible next cycle", pdata(3), 16'h7C7C);

        // R7: three cores push to q5 (c1 vq3, c2 vq0, c3 vq5)
        next_cycle(); push(1, 3, 16'h0101); push(2, 0, 16'h0202); push(3, 5, 16'h0303); #1;
        chk("R7", "push grants lowest core", int'(prod_ready), 4'b0010);
        next_cycle(); pop(3, 5); pop(0, 5); #1;
        chk("R7", "pop grants lowest core", int'(cons_ready), 4'b0001);
        chk("R7", "winner's word", pdata(0), 16'h0101);
        next_cycle(); pop(3, 5); #1;
        chk("R7", "losing pushes not written", int'(cons_ready), 0);

        // R4: base write same cycle as push uses old base
        next_cycle(); setb(0, 3); push(0, 0, 16'h0A0A); #1;
        chk("R4", "push with base write", int'(prod_ready[0]), 1);
        next_cycle(); pop(3, 0); #1;
        chk("R4", "old base used same cycle", pdata(3), 16'h0A0A);
        next_cycle(); push(0, 0, 16'h0B0B); #1;
        next_cycle(); pop(3, 3); #1;
        chk("R4", "new base used after", pdata(3), 16'h0B0B);

        // R8: reset mid-run clears queues and bases
        next_cycle(); push(0, 0, 16'h0C0C); #1;
        next_cycle(); rst_n = 1'b0;
        next_cycle(); rst_n = 1'b1;
        next_cycle(); pop(3, 3); #1;
        chk("R8", "queue emptied by reset", int'(cons_ready[3]), 0);
        next_cycle(); push(0, 0, 16'h0D0D); #1;
        next_cycle(); pop(3, 0); #1;
        chk("R8", "base cleared by reset", pdata(3), 16'h0D0D);

        next_cycle();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule